// File: doc/BRIEF.md
# Lossless Two-Input Merge Buffer

This block merges two streams into one. On every clock cycle each input, A and B, either carries one data word or is absent, marked by its valid bit. The output carries at most one word per cycle from a register, with the same valid marking. Sometimes more words arrive than can leave in a cycle. This happens when both inputs are valid together, or when words are already waiting. The surplus goes into a small internal ring buffer and is never discarded while there is room.

Words leave strictly in order of arrival cycle. Buffered words always go before newly arriving ones. Within one cycle the word on A goes before the word on B. An occupancy count and a full flag show how many words are waiting. If a word has to be stored while no slot is free, that word is dropped and a sticky overflow flag is raised. The flag stays set until reset.

Top module: `merge2_buf`

## Requirements
- R1: When the buffer is empty and neither input is valid, `out_vld` is low in the following cycle. Whenever a word is buffered or arriving, `out_vld` is high in the following cycle.
- R2: With the buffer empty and exactly one input valid, that input's word appears on `out_dat` with `out_vld` high one clock cycle later, and nothing is buffered.
- R3: While the buffer is not full, no word is lost. The occupancy plus the number of valid inputs in a cycle equals the next cycle's occupancy plus `out_vld`.
- R4: Words leave in order of arrival cycle. A word that is already buffered is emitted before any word arriving in a later or the same cycle.
- R5: When A and B are valid in the same cycle, the word from A is emitted before the word from B.
- R6: `occupancy` never exceeds DEPTH, and `full` is high exactly when `occupancy` equals DEPTH.
- R7: If a word must be stored while no slot is free, that word, which is the newest one, is dropped, all older words are kept, and `overflow` goes high in the next cycle. When the buffer is full and a single word arrives, no overflow occurs, because the emitted word frees a slot.
- R8: Once set, `overflow` stays high until reset.
- R9: While `rst_n` is low, `out_vld`, `occupancy`, `full` and `overflow` are all zero, even if words were buffered before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_vld | input | 1 | Input A carries a word this cycle |
| a_dat | input | W | Input A word |
| b_vld | input | 1 | Input B carries a word this cycle |
| b_dat | input | W | Input B word |
| out_vld | output | 1 | Output word present |
| out_dat | output | W | Output word |
| occupancy | output | $clog2(DEPTH+1) | Number of buffered words |
| full | output | 1 | Buffer holds DEPTH words |
| overflow | output | 1 | Sticky: a word was dropped |

## Verification
Three events can fall in one cycle: the buffer releases its oldest word, and both inputs push a word, so there is one pop and two writes at once. The stimulus table drives back-to-back cycles with both inputs valid. This keeps the head leaving while A and B enter behind it. Each output word and the occupancy are compared with a queue model that appends A and then B every cycle. Near the depth limit, a pop coincides with an overflow decision. This is tested at full with both inputs valid, where B must be dropped, and at full with a single input, where nothing is lost.

// File: rtl/merge2_buf.sv
module merge2_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_vld,
  input  logic [W-1:0]  a_dat,
  input  logic          b_vld,
  input  logic [W-1:0]  b_dat,
  output logic          out_vld,
  output logic [W-1:0]  out_dat,
  output logic [CW-1:0] occupancy,
  output logic          full,
  output logic          overflow
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW:0] DEP = (CW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, wr_ptr1;
  logic [CW-1:0] cnt;
  logic          ovf_q;

  logic          have_q;
  logic          nxt_vld;
  logic [W-1:0]  nxt_dat;
  logic          p0_v, p1_v, acc0, acc1, lose;
  logic [W-1:0]  p0_d, p1_d;
  logic [CW:0]   keep, space, cnt_n;

  assign have_q  = (cnt != '0);
  assign wr_ptr1 = wr_ptr + 1'b1;

  // head of buffer first, then A, then B
  assign nxt_vld = have_q | a_vld | b_vld;
  assign nxt_dat = have_q ? mem[rd_ptr] : (a_vld ? a_dat : b_dat);

  always_comb begin
    p0_v = 1'b0;
    p0_d = b_dat;
    p1_v = 1'b0;
    p1_d = b_dat;
    if (have_q) begin
      if (a_vld) begin
        p0_v = 1'b1;
        p0_d = a_dat;
        p1_v = b_vld;
      end else begin
        p0_v = b_vld;
      end
    end else begin
      p0_v = a_vld & b_vld;
    end
  end

  assign keep  = {1'b0, cnt} - {{CW{1'b0}}, have_q};
  assign space = DEP - keep;
  assign acc0  = p0_v && (space != '0);
  assign acc1  = p1_v && (space >= 2);
  assign lose  = (p0_v && !acc0) || (p1_v && !acc1);
  assign cnt_n = keep + {{CW{1'b0}}, acc0} + {{CW{1'b0}}, acc1};

  always_ff @(posedge clk) begin
    if (acc0) mem[wr_ptr]  <= p0_d;
    if (acc1) mem[wr_ptr1] <= p1_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      cnt     <= '0;
      ovf_q   <= 1'b0;
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      if (have_q) rd_ptr <= rd_ptr + 1'b1;
      if (acc1)      wr_ptr <= wr_ptr + 2'd2;
      else if (acc0) wr_ptr <= wr_ptr + 1'b1;
      cnt     <= cnt_n[CW-1:0];
      ovf_q   <= ovf_q | lose;
      out_vld <= nxt_vld;
      if (nxt_vld) out_dat <= nxt_dat;
    end
  end

  assign occupancy = cnt;
  assign full      = (cnt == DEP[CW-1:0]);
  assign overflow  = ovf_q;

endmodule

module merge2_buf_chk #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_vld,
  input logic [W-1:0]  a_dat,
  input logic          b_vld,
  input logic [W-1:0]  b_dat,
  input logic          out_vld,
  input logic [W-1:0]  out_dat,
  input logic [CW-1:0] occupancy,
  input logic          full,
  input logic          overflow
);

  logic [CW+1:0] in_sum, out_sum;
  assign in_sum  = {2'b00, occupancy} + {{(CW+1){1'b0}}, a_vld} + {{(CW+1){1'b0}}, b_vld};
  assign out_sum = {2'b00, occupancy} + {{(CW+1){1'b0}}, out_vld};

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0 && !a_vld && !b_vld) |=> !out_vld);
  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy != '0 || a_vld || b_vld) |=> out_vld);
  p_single_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0 && a_vld && !b_vld) |=> (out_vld && out_dat == $past(a_dat) && occupancy == '0));
  p_single_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0 && !a_vld && b_vld) |=> (out_vld && out_dat == $past(b_dat) && occupancy == '0));
  p_no_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !full |=> (out_sum == $past(in_sum)));
  p_tie_a_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0 && a_vld && b_vld) |=> (out_dat == $past(a_dat) && occupancy == CW'(1)));
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy <= CW'(DEPTH)) && (full == (occupancy == CW'(DEPTH))));
  p_full_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && a_vld && b_vld) |=> overflow);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

bind merge2_buf merge2_buf_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_vld(a_vld), .a_dat(a_dat), .b_vld(b_vld),
  .b_dat(b_dat), .out_vld(out_vld), .out_dat(out_dat), .occupancy(occupancy),
  .full(full), .overflow(overflow)
);

// File: tb/merge2_buf_test.sv
module merge2_buf_test;
  localparam int W = 8;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NV = 20;
  // {a_vld, a_dat, b_vld, b_dat}
  localparam logic [2*W+1:0] VEC [NV] = '{
    {1'b1, 8'h11, 1'b0, 8'h00},  // R2 single A
    {1'b0, 8'h00, 1'b0, 8'h00},  // R1 idle
    {1'b0, 8'h00, 1'b1, 8'h22},  // R2 single B
    {1'b1, 8'h31, 1'b1, 8'h32},  // R5 tie
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b1, 8'h41, 1'b1, 8'h42},  // R4 burst
    {1'b1, 8'h51, 1'b1, 8'h52},
    {1'b1, 8'h61, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b1, 8'h72},
    {1'b1, 8'h81, 1'b1, 8'h82},
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b1, 8'h91, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00},
    {1'b1, 8'hA1, 1'b1, 8'hA2},
    {1'b0, 8'h00, 1'b1, 8'hB2},
    {1'b0, 8'h00, 1'b0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_vld = 1'b0, b_vld = 1'b0;
  logic [W-1:0] a_dat = '0, b_dat = '0;
  logic out_vld, full, overflow;
  logic [W-1:0] out_dat;
  logic [CW-1:0] occupancy;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] refq[$];
  logic [W-1:0] seen[$];

  always #4 clk = ~clk;

  merge2_buf #(.W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .a_vld(a_vld), .a_dat(a_dat), .b_vld(b_vld),
    .b_dat(b_dat), .out_vld(out_vld), .out_dat(out_dat), .occupancy(occupancy),
    .full(full), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic av, input logic [W-1:0] ad, input logic bv, input logic [W-1:0] bd);
    a_vld = av; a_dat = ad; b_vld = bv; b_dat = bd;
    @(posedge clk);
    @(negedge clk);
    if (out_vld) seen.push_back(out_dat);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    a_vld = 1'b0; b_vld = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    refq.delete();
    seen.delete();
  endtask

  task automatic model_step(input logic av, input logic [W-1:0] ad, input logic bv, input logic [W-1:0] bd);
    logic ev;
    logic [W-1:0] ed;
    if (av) refq.push_back(ad);
    if (bv) refq.push_back(bd);
    ev = (refq.size() != 0);
    ed = ev ? refq.pop_front() : '0;
    drive(av, ad, bv, bd);
    check("R1 out_vld", int'(out_vld), int'(ev));
    if (ev) check("R4/R5 order", int'(out_dat), int'(ed));
    check("R3 occupancy", int'(occupancy), refq.size());
    check("R6 full", int'(full), int'(refq.size() == DEPTH));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 out_vld", int'(out_vld), 0);
    check("R9 occupancy", int'(occupancy), 0);
    check("R9 overflow", int'(overflow), 0);
    do_reset();

    for (int i = 0; i < NV; i++)
      model_step(VEC[i][2*W+1], VEC[i][2*W:W+1], VEC[i][W], VEC[i][W-1:0]);
    check("R7 no overflow in table", int'(overflow), 0);

    // R7: overflow at full with both valid, newest (B) dropped
    do_reset();
    for (int i = 1; i <= 4; i++) drive(1'b1, 8'h10 + 8'(i), 1'b1, 8'h20 + 8'(i));
    check("R6 full after four pairs", int'(full), 1);
    check("R7 no overflow yet", int'(overflow), 0);
    drive(1'b1, 8'h15, 1'b1, 8'h25);
    check("R7 overflow set", int'(overflow), 1);
    check("R6 occupancy capped", int'(occupancy), DEPTH);
    for (int i = 0; i < 6; i++) drive(1'b0, '0, 1'b0, '0);
    check("R8 overflow sticky", int'(overflow), 1);
    check("R7 kept count", seen.size(), 9);
    for (int i = 0; i < 9 && i < seen.size(); i++)
      check("R7 kept order", int'(seen[i]),
            (i % 2 == 0) ? int'(8'h11) + i / 2 : int'(8'h21) + i / 2);

    // R9 reset clears a nonempty buffer and the overflow flag
    for (int i = 1; i <= 3; i++) drive(1'b1, 8'h40, 1'b1, 8'h41);
    rst_n = 1'b0;
    a_vld = 1'b0; b_vld = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9 occupancy cleared", int'(occupancy), 0);
    check("R9 overflow cleared", int'(overflow), 0);
    check("R9 out_vld cleared", int'(out_vld), 0);
    rst_n = 1'b1;
    drive(1'b0, '0, 1'b0, '0);
    check("R1 idle after reset", int'(out_vld), 0);

    // R7: full plus a single word does not overflow
    do_reset();
    for (int i = 1; i <= 4; i++) drive(1'b1, 8'h50 + 8'(i), 1'b1, 8'h60 + 8'(i));
    drive(1'b1, 8'h77, 1'b0, '0);
    check("R7 single at full no overflow", int'(overflow), 0);
    check("R6 still full", int'(occupancy), DEPTH);
    for (int i = 0; i < 6; i++) drive(1'b0, '0, 1'b0, '0);
    check("R3 all kept", seen.size(), 9);
    if (seen.size() == 9) check("R4 last word", int'(seen[8]), int'(8'h77));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule